// File: doc/BRIEF.md
# Multi-Vector Interrupt Controller

This block gathers interrupt conditions for a small 8-bit processor core and turns them into one request line, a 2-bit vector number and a wake-up signal. Three core sources have vectors of their own: an external pin edge, a timer-0 overflow and an edge on the timer clock input. A parameterised set of peripheral sources, fifteen by default, share a fourth vector through one group request.

Each source has a sticky flag and an enable. A group enable gates the peripheral group, and a global disable bit blocks the request to the CPU. The CPU accepts a request with a one-cycle acknowledge strobe. On that strobe the global disable bit is set and, for a core vector, the source flag is cleared. A return strobe clears the global disable bit again. Peripheral flags are cleared only by software writes through an 8-bit register window. Its write strobe and combinational read path are plain control pins: every write lands in the cycle it is presented, with no back-pressure.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset all flags and enables read 0, the global disable bit reads 1, and irq_req and wake are 0.
- R2: An event pulse sets its flag at the next clock edge whatever the enables and the global disable bit hold. If it coincides with a software write of 0 or an acknowledge clear of the same flag, the flag ends set.
- R3: irq_req is 1 exactly when the global disable bit is 0 and some source is enabled and pending. A core source is pending when its flag and enable are both 1. The peripheral group is pending when the group enable is 1 and any peripheral has flag and enable both 1.
- R4: The group flag (address 0 bit 3, read-only) is the OR over peripherals of flag AND enable, and does not depend on the group enable.
- R5: irq_vec encodes 0 = external pin, 1 = timer-0 overflow, 2 = timer clock edge, 3 = peripheral group. Among pending sources, lower codes take priority.
- R6: An acknowledge while irq_req is 1 sets the global disable bit at that edge. If irq_vec is 0, 1 or 2, the same edge clears the flag of that core source.
- R7: An acknowledge on vector 3 leaves every peripheral flag unchanged, so the request returns after the return strobe until software clears the flags.
- R8: The return strobe clears the global disable bit. When it coincides with a taken acknowledge, the bit ends set.
- R9: wake equals sleep_mode AND (some source enabled and pending), independent of the global disable bit.
- R10: Register window with 8-bit data; a write replaces the addressed register. Address 0 holds the core flags in bits 2..0 (ext, tmr0, tclk), with the group flag in bit 3. Address 1 holds the core enables in bits 2..0 and the group enable in bit 3. Address 2 holds the global disable in bit 0. Addresses 3 and 4 hold peripheral flags 7..0 and 14..8, addresses 5 and 6 hold peripheral enables 7..0 and 14..8. Unused bits and address 7 read 0.
- R11: An acknowledge while irq_req is 0 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_evt | input | 3 | Core event pulses: bit 0 ext pin, bit 1 timer-0, bit 2 timer clock edge |
| periph_evt | input | NUM_PERIPH | Peripheral event pulses |
| sleep_mode | input | 1 | Core is sleeping |
| irq_ack | input | 1 | One-cycle acceptance strobe from the CPU |
| irq_retfie | input | 1 | One-cycle return-from-interrupt strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 2 | Selected vector |
| wake | output | 1 | Wake-up request |

## Verification
The bench builds the block with the default of fifteen peripheral sources. That gives two peripheral bytes per bank, with the upper byte only partly filled, so readback of the padding bit and of the one unmapped address are both reachable. A behavioural model compares the request, vector, wake and read data every cycle. Directed sequences walk all four vectors through acknowledge and return. They also make set/clear collisions and acknowledges without a request, followed by a long random phase.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    VEC_EXT    = 2'd0,
    VEC_TMR0   = 2'd1,
    VEC_TCLK   = 2'd2,
    VEC_PERIPH = 2'd3
  } irq_vec_e;

  localparam int CORE_SRCS   = 3;
  localparam int DATA_W      = 8;
  localparam int REG_CFLAG   = 0;
  localparam int REG_CEN     = 1;
  localparam int REG_GLOBAL  = 2;
  localparam int REG_PF_BASE = 3;
endpackage

// File: rtl/irq_bitreg.sv
module irq_bitreg #(
  parameter int W  = 8,
  parameter int NB = (W + 7) / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  hw_set,
  input  logic [W-1:0]  hw_clr,
  input  logic [NB-1:0] wr_byte,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  q
);
  // per bit: hardware set > hardware clear > software write > hold
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[i] <= 1'b0;
      else if (hw_set[i])
        q[i] <= 1'b1;
      else if (hw_clr[i])
        q[i] <= 1'b0;
      else if (wr_byte[i/8])
        q[i] <= wr_data[i];
    end
  end
endmodule

// File: rtl/irq_vec_sel.sv
module irq_vec_sel
  import irq_pkg::*;
(
  input  logic [CORE_SRCS-1:0] core_pend,
  input  logic                 grp_pend,
  output logic                 any_pend,
  output irq_vec_e             vec
);
  always_comb begin
    any_pend = (|core_pend) | grp_pend;
    if (core_pend[0])      vec = VEC_EXT;
    else if (core_pend[1]) vec = VEC_TMR0;
    else if (core_pend[2]) vec = VEC_TCLK;
    else                   vec = VEC_PERIPH;
  end
endmodule

// File: rtl/irq_regmap.sv
module irq_regmap
  import irq_pkg::*;
#(
  parameter int NP   = 15,
  parameter int PB   = (NP + 7) / 8,
  parameter int NREG = REG_PF_BASE + 2 * PB,
  parameter int AW   = $clog2(NREG)
) (
  input  logic                 reg_we,
  input  logic [AW-1:0]        reg_addr,
  input  logic [CORE_SRCS-1:0] cflag,
  input  logic [CORE_SRCS:0]   cen,
  input  logic                 gdis,
  input  logic                 grp_flag,
  input  logic [NP-1:0]        pflag,
  input  logic [NP-1:0]        pen,
  output logic                 wr_cflag,
  output logic                 wr_cen,
  output logic                 wr_glob,
  output logic [PB-1:0]        wr_pflag,
  output logic [PB-1:0]        wr_pen,
  output logic [DATA_W-1:0]    rdata
);
  logic [PB*8-1:0]     pf_pad, pe_pad;
  logic [DATA_W-1:0]   regs [NREG];

  always_comb begin
    wr_cflag = reg_we && (reg_addr == AW'(REG_CFLAG));
    wr_cen   = reg_we && (reg_addr == AW'(REG_CEN));
    wr_glob  = reg_we && (reg_addr == AW'(REG_GLOBAL));
    for (int p = 0; p < PB; p++) begin
      wr_pflag[p] = reg_we && (reg_addr == AW'(REG_PF_BASE + p));
      wr_pen[p]   = reg_we && (reg_addr == AW'(REG_PF_BASE + PB + p));
    end
  end

  always_comb begin
    pf_pad = '0;
    pe_pad = '0;
    pf_pad[NP-1:0] = pflag;
    pe_pad[NP-1:0] = pen;
    regs[REG_CFLAG]  = {{(DATA_W-CORE_SRCS-1){1'b0}}, grp_flag, cflag};
    regs[REG_CEN]    = {{(DATA_W-CORE_SRCS-1){1'b0}}, cen};
    regs[REG_GLOBAL] = {{(DATA_W-1){1'b0}}, gdis};
    for (int p = 0; p < PB; p++) begin
      regs[REG_PF_BASE + p]      = pf_pad[p*8 +: 8];
      regs[REG_PF_BASE + PB + p] = pe_pad[p*8 +: 8];
    end
    rdata = '0;
    for (int k = 0; k < NREG; k++)
      if (reg_addr == AW'(k)) rdata = regs[k];
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_PERIPH = 15,
  parameter int PB   = (NUM_PERIPH + 7) / 8,
  parameter int NREG = REG_PF_BASE + 2 * PB,
  parameter int AW   = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CORE_SRCS-1:0]  core_evt,
  input  logic [NUM_PERIPH-1:0] periph_evt,
  input  logic                  sleep_mode,
  input  logic                  irq_ack,
  input  logic                  irq_retfie,
  input  logic                  reg_we,
  input  logic [AW-1:0]         reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic                  irq_req,
  output logic [1:0]            irq_vec,
  output logic                  wake
);
  logic [CORE_SRCS-1:0]  cflag, core_clr, core_pend;
  logic [CORE_SRCS:0]    cen;
  logic [NUM_PERIPH-1:0] pflag, pen, pdata;
  logic                  gdis, grp_flag, grp_pend, any_pend, take;
  logic                  wr_cflag, wr_cen, wr_glob;
  logic [PB-1:0]         wr_pflag, wr_pen;
  irq_vec_e              vec;

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_pdata
    assign pdata[i] = reg_wdata[i % 8];
  end

  irq_regmap #(.NP(NUM_PERIPH)) u_regmap (
    .reg_we(reg_we), .reg_addr(reg_addr), .cflag(cflag), .cen(cen),
    .gdis(gdis), .grp_flag(grp_flag), .pflag(pflag), .pen(pen),
    .wr_cflag(wr_cflag), .wr_cen(wr_cen), .wr_glob(wr_glob),
    .wr_pflag(wr_pflag), .wr_pen(wr_pen), .rdata(reg_rdata)
  );

  irq_bitreg #(.W(CORE_SRCS)) u_cflag (
    .clk(clk), .rst_n(rst_n), .hw_set(core_evt), .hw_clr(core_clr),
    .wr_byte(wr_cflag), .wr_data(reg_wdata[CORE_SRCS-1:0]), .q(cflag)
  );

  irq_bitreg #(.W(CORE_SRCS+1)) u_cen (
    .clk(clk), .rst_n(rst_n), .hw_set('0), .hw_clr('0),
    .wr_byte(wr_cen), .wr_data(reg_wdata[CORE_SRCS:0]), .q(cen)
  );

  irq_bitreg #(.W(NUM_PERIPH)) u_pflag (
    .clk(clk), .rst_n(rst_n), .hw_set(periph_evt), .hw_clr('0),
    .wr_byte(wr_pflag), .wr_data(pdata), .q(pflag)
  );

  irq_bitreg #(.W(NUM_PERIPH)) u_pen (
    .clk(clk), .rst_n(rst_n), .hw_set('0), .hw_clr('0),
    .wr_byte(wr_pen), .wr_data(pdata), .q(pen)
  );

  assign grp_flag  = |(pflag & pen);
  assign grp_pend  = grp_flag & cen[CORE_SRCS];
  assign core_pend = cflag & cen[CORE_SRCS-1:0];

  irq_vec_sel u_sel (
    .core_pend(core_pend), .grp_pend(grp_pend),
    .any_pend(any_pend), .vec(vec)
  );

  assign irq_req = any_pend & ~gdis;
  assign irq_vec = vec;
  assign wake    = sleep_mode & any_pend;
  assign take    = irq_ack & irq_req;

  always_comb begin
    core_clr = '0;
    if (take && vec != VEC_PERIPH) core_clr[vec] = 1'b1;
  end

  // acknowledge > return > software write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gdis <= 1'b1;
    else if (take)       gdis <= 1'b1;
    else if (irq_retfie) gdis <= 1'b0;
    else if (wr_glob)    gdis <= reg_wdata[0];
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
  import irq_pkg::*;
#(
  parameter int NUM_PERIPH = 15,
  parameter int AW = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [CORE_SRCS-1:0]  core_evt,
  input logic [NUM_PERIPH-1:0] periph_evt,
  input logic                  sleep_mode,
  input logic                  irq_ack,
  input logic                  irq_retfie,
  input logic                  reg_we,
  input logic [AW-1:0]         reg_addr,
  input logic [DATA_W-1:0]     reg_wdata,
  input logic                  irq_req,
  input logic [1:0]            irq_vec,
  input logic                  wake,
  input logic                  gdis,
  input logic [CORE_SRCS-1:0]  cflag,
  input logic [CORE_SRCS:0]    cen,
  input logic [NUM_PERIPH-1:0] pflag
);
  a_r3_req_only_open: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !gdis);

  a_r5_ext_first: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && cflag[0] && cen[0]) |-> irq_vec == 2'd0);

  a_r6_take_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> gdis);

  a_r6_ext_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && irq_vec == 2'd0 && !core_evt[0]
     && !(reg_we && reg_addr == '0 && reg_wdata[0])) |=> !cflag[0]);

  a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_evt != '0) |=> ((pflag & $past(periph_evt)) == $past(periph_evt)));

  a_r7_periph_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && irq_vec == 2'd3 && !reg_we)
      |=> ((pflag & $past(pflag)) == $past(pflag)));

  a_r8_ret_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_retfie && !(irq_ack && irq_req)) |=> !gdis);

  a_r9_wake_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> sleep_mode);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NUM_PERIPH(NUM_PERIPH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_evt(core_evt), .periph_evt(periph_evt),
  .sleep_mode(sleep_mode), .irq_ack(irq_ack), .irq_retfie(irq_retfie),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .irq_req(irq_req), .irq_vec(irq_vec), .wake(wake), .gdis(gdis),
  .cflag(cflag), .cen(cen), .pflag(pflag)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  localparam int NP = 15;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    core_evt = '0;
  logic [NP-1:0] periph_evt = '0;
  logic          sleep_mode = 1'b0, irq_ack = 1'b0, irq_retfie = 1'b0, reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          irq_req, wake;
  logic [1:0]    irq_vec;

  int compared = 0, mismatched = 0, cycles = 0;
  string scen = "R1";

  // behavioural reference state
  bit [2:0]    m_cf;
  bit [3:0]    m_ce;
  bit [NP-1:0] m_pf, m_pe;
  bit          m_gd;

  always #10 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .core_evt(core_evt), .periph_evt(periph_evt),
    .sleep_mode(sleep_mode), .irq_ack(irq_ack), .irq_retfie(irq_retfie),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_vec(irq_vec), .wake(wake)
  );

  function automatic bit m_any();
    return (|(m_cf & m_ce[2:0])) || (m_ce[3] && (|(m_pf & m_pe)));
  endfunction

  function automatic int m_vec();
    if (m_cf[0] && m_ce[0]) return 0;
    if (m_cf[1] && m_ce[1]) return 1;
    if (m_cf[2] && m_ce[2]) return 2;
    return 3;
  endfunction

  function automatic bit [7:0] m_rd(int a);
    bit [15:0] pf, pe;
    pf = 16'(m_pf);
    pe = 16'(m_pe);
    case (a)
      0: return {4'b0, |(m_pf & m_pe), m_cf};
      1: return {4'b0, m_ce};
      2: return {7'b0, m_gd};
      3: return pf[7:0];
      4: return pf[15:8];
      5: return pe[7:0];
      6: return pe[15:8];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cf = '0; m_ce = '0; m_pf = '0; m_pe = '0; m_gd = 1'b1;
    end else begin
      bit take;
      int v;
      bit [2:0] ncf;
      bit [NP-1:0] npf, npe;
      take = irq_ack && m_any() && !m_gd;
      v = m_vec();
      ncf = m_cf; npf = m_pf; npe = m_pe;
      if (reg_we && reg_addr == 0) ncf = reg_wdata[2:0];
      if (take && v < 3) ncf[v] = 1'b0;
      ncf |= core_evt;
      for (int i = 0; i < NP; i++) begin
        if (reg_we && int'(reg_addr) == 3 + i/8) npf[i] = reg_wdata[i%8];
        if (reg_we && int'(reg_addr) == 5 + i/8) npe[i] = reg_wdata[i%8];
      end
      npf |= periph_evt;
      if (reg_we && reg_addr == 1) m_ce = reg_wdata[3:0];
      if (take) m_gd = 1'b1;
      else if (irq_retfie) m_gd = 1'b0;
      else if (reg_we && reg_addr == 2) m_gd = reg_wdata[0];
      m_cf = ncf; m_pf = npf; m_pe = npe;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s [%s] %s actual=%0h expected=%0h at %0t", req, scen, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R3", "irq_req", int'(irq_req), int'(m_any() && !m_gd));
    check("R9", "wake", int'(wake), int'(sleep_mode && m_any()));
    check("R10", "reg_rdata", int'(reg_rdata), int'(m_rd(int'(reg_addr))));
    if (m_any()) check("R5", "irq_vec", int'(irq_vec), m_vec());
  endtask

  // drive at negedge, compare 5 ns later, advance to next negedge
  task automatic step(input bit [2:0] ce, input bit [NP-1:0] pe, input bit ack,
                      input bit ret, input bit we, input int a, input bit [7:0] wd);
    core_evt = ce; periph_evt = pe; irq_ack = ack; irq_retfie = ret;
    reg_we = we; reg_addr = AW'(a); reg_wdata = wd;
    #5;
    compare_all();
    @(negedge clk);
  endtask

  task automatic rd(int a);
    step(3'b0, '0, 0, 0, 0, a, 8'h00);
  endtask

  task automatic wr(int a, bit [7:0] d);
    step(3'b0, '0, 0, 0, 1, a, d);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values at every address
    scen = "R1";
    for (int a = 0; a < 8; a++) rd(a);
    // R2: events set flags with everything disabled; set beats clear
    scen = "R2";
    step(3'b001, 15'h4000, 0, 0, 0, 0, 8'h00);
    rd(0); rd(4);
    step(3'b000, 15'h0001, 0, 0, 1, 3, 8'h00);
    rd(3);
    // R4: group flag ignores group enable
    scen = "R4";
    wr(6, 8'h40); rd(0);
    // R3: open global and enable ext
    scen = "R3";
    wr(2, 8'h00); wr(1, 8'h01); rd(0);
    // R5 / R6 / R7: walk all vectors
    scen = "R5";
    wr(0, 8'h07); wr(1, 8'h0F); rd(0);
    scen = "R6";
    for (int k = 0; k < 3; k++) begin
      step(3'b0, '0, 1, 0, 0, 0, 8'h00);
      rd(2);
      step(3'b0, '0, 0, 1, 0, 0, 8'h00);
    end
    scen = "R7";
    step(3'b0, '0, 1, 0, 0, 3, 8'h00);
    rd(3); rd(4);
    step(3'b0, '0, 0, 1, 0, 2, 8'h00);
    wr(3, 8'h00); wr(4, 8'h00); rd(0);
    // R11: acknowledge with no request
    scen = "R11";
    step(3'b0, '0, 1, 0, 0, 2, 8'h00);
    rd(2); rd(0);
    // R8: acknowledge and return together
    scen = "R8";
    step(3'b010, '0, 0, 0, 0, 0, 8'h00);
    step(3'b0, '0, 1, 1, 0, 2, 8'h00);
    rd(2);
    // R9: wake while globally disabled
    scen = "R9";
    sleep_mode = 1'b1;
    step(3'b100, '0, 0, 0, 0, 0, 8'h00);
    rd(0);
    wr(1, 8'h00); rd(2);
    sleep_mode = 1'b0;
    // random phase
    scen = "RAND";
    for (int n = 0; n < 4000; n++) begin
      bit [NP-1:0] pe;
      pe = NP'($urandom & $urandom & $urandom & $urandom);
      sleep_mode = $urandom_range(0, 3) == 0;
      step(3'($urandom & $urandom & $urandom), pe,
           $urandom_range(0, 3) == 0, $urandom_range(0, 5) == 0,
           $urandom_range(0, 4) == 0, $urandom_range(0, 7), 8'($urandom));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule